// File: doc/BRIEF.md
# Configuration Transaction Engine

This block runs one configuration access at a time against a small set of board resources: a writable table of main-board oscillator frequencies, a writable table of daughterboard oscillator frequencies, a fixed main-board bus-voltage reading and a set of daughterboard voltage sensors. Software sees three 32-bit registers: a data register, a control register and a status register. Writing the control register with its top bit set starts a transaction. The engine decodes the routing fields of the stored word, validates the target, performs the read or write, and records completion and error in the status register. A successful read leaves its result in the data register.

The daughterboard oscillator reset values and the daughterboard sensor readings come in on ports. A separate enable input decides whether the register window exists at all. Power-off and restart requests are not acted on inside the block. They leave as single-cycle request pulses for the rest of the chip.

A transaction finishes on the clock edge that follows the start write. The status register reads 0 during that one pending cycle and holds the outcome from the cycle after.

Top module: `cfg_txn_engine`

## Requirements
- R1: After reset the data, control and status registers read 0. Main-board oscillator entries 0 to 5 hold 50000000, 23750000, 24000000, 24000000, 24000000 and 24000000.
- R2: The control word layout is:
  - bit 31: start
  - bit 30: write when 1, read when 0
  - bits 29:26: controller number
  - bits 25:20: function
  - bits 17:16: site
  - bits 15:12: stack position
  - bits 11:0: device

  Bits 31, 19 and 18 are never stored and always read back as 0. All other bits read back as written.
- R3: A control write with bit 31 set clears the status register to 0 in the following cycle. In the cycle after that, status bit 0 (complete) is 1 and status bit 1 (error) is 1 when the transaction failed.
- R4: A transaction fails unless all three routing conditions hold: the controller number is 0, the stack position is 0, and the site is 0 (main board) or 1 (daughterboard).
- R5: Only these function codes can succeed: 1 oscillator, 2 voltage, 8 power-off, 9 restart, 11 display mode. Every other code fails. Power-off, restart and display mode also fail as reads, and voltage fails as a write.
- R6: Oscillator transactions succeed for device indexes below 6 at site 0 and below `DTR_OSC_N` at site 1, and fail otherwise. A write stores the data register value as it stood at the start write; a data write during the pending cycle does not change the stored value.
- R7: A voltage read at site 0 succeeds only for device 0 and returns 3300000. A voltage read at site 1 succeeds for device indexes below `DTR_VSENS_N` and returns entry `device` of `dtr_volt`, where entry i is bits 32*i+31:32*i.
- R8: A successful read transaction loads its result into the data register. A failed read, and any write transaction, leave the data register unchanged.
- R9: A write with function 8 or 9 at site 0, device 0 raises `pwr_off_req` or `restart_req` respectively for exactly one cycle, in the cycle where status first shows 1. A display-mode write at site 0, device 0 succeeds without a pulse. Any failing transaction raises no pulse.
- R10: A write to the status register stores only bits 1:0 of the write data.
- R11: While `variant_en` is 0, all three registers read as 0 and writes to them are ignored.
- R12: The registers sit at byte offsets 0xA0 (data), 0xA4 (control) and 0xA8 (status). Every other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| variant_en | input | 1 | Enables the register window |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| dtr_osc_init | input | 32*DTR_OSC_N | Reset values of the daughterboard oscillator table |
| dtr_volt | input | 32*DTR_VSENS_N | Daughterboard voltage sensor readings |
| pwr_off_req | output | 1 | Single-cycle power-off request |
| restart_req | output | 1 | Single-cycle restart request |

## Verification
The engine is exercised with control words that vary one routing field at a time. Each of the three routing fields is set in turn to a rejected value, so each condition is shown to cause an error independently of the others. Oscillator and voltage words step the device index to just below and just at each table bound, which separates the main-board limit from the daughterboard limits. Writes with a changed data register before the start and a different value during the pending cycle tell the start-time snapshot apart from the live register. Power-off, restart and display-mode words are sent both as writes and as reads and at a non-zero device, which separates a pulse from a completion alone.

// File: rtl/cfg_txn_pkg.sv
package cfg_txn_pkg;

   localparam int WORD_W = 32;
   localparam int OFS_W  = 12;
   localparam int DEV_W  = 12;

   localparam logic [OFS_W-1:0] OFS_DATA = 12'hA0;
   localparam logic [OFS_W-1:0] OFS_CTRL = 12'hA4;
   localparam logic [OFS_W-1:0] OFS_STAT = 12'hA8;

   // start bit and the two undefined bits are dropped on store
   localparam logic [WORD_W-1:0] CTRL_KEEP = 32'h7FF3_FFFF;

   localparam logic [1:0] SITE_MAIN     = 2'd0;
   localparam logic [1:0] SITE_DAUGHTER = 2'd1;

   typedef struct packed {
      logic             start;
      logic             wr;
      logic [3:0]       unit;
      logic [5:0]       func;
      logic [1:0]       rsvd;
      logic [1:0]       site;
      logic [3:0]       pos;
      logic [DEV_W-1:0] dev;
   } cfg_word_t;

   localparam logic [5:0] FN_OSC     = 6'd1;
   localparam logic [5:0] FN_VOLT    = 6'd2;
   localparam logic [5:0] FN_PWROFF  = 6'd8;
   localparam logic [5:0] FN_RESTART = 6'd9;
   localparam logic [5:0] FN_DISP    = 6'd11;

   typedef enum logic [2:0] {
      TG_NONE,
      TG_OSC_MAIN,
      TG_OSC_DTR,
      TG_VOLT_MAIN,
      TG_VOLT_DTR,
      TG_PWROFF,
      TG_RESTART,
      TG_DISP
   } cfg_tgt_e;

endpackage

// File: rtl/cfg_txn_decode.sv
module cfg_txn_decode
   import cfg_txn_pkg::*;
#(
   parameter int MAIN_OSC_N  = 6,
   parameter int DTR_OSC_N   = 2,
   parameter int DTR_VSENS_N = 2
)(
   input  cfg_word_t word,
   output cfg_tgt_e  tgt,
   output logic      ok
);

   localparam logic [DEV_W-1:0] MAIN_LIM = DEV_W'(MAIN_OSC_N);
   localparam logic [DEV_W-1:0] DTR_LIM  = DEV_W'(DTR_OSC_N);
   localparam logic [DEV_W-1:0] VS_LIM   = DEV_W'(DTR_VSENS_N);

   logic route_ok;
   logic at_main;
   logic at_dtr;
   logic dev_zero;

   assign at_main  = (word.site == SITE_MAIN);
   assign at_dtr   = (word.site == SITE_DAUGHTER);
   assign dev_zero = (word.dev == '0);
   assign route_ok = (word.unit == '0) && (word.pos == '0) && (at_main || at_dtr);

   always_comb begin
      tgt = TG_NONE;
      case (word.func)
         FN_OSC: begin
            if (at_main && (word.dev < MAIN_LIM))
               tgt = TG_OSC_MAIN;
            else if (at_dtr && (word.dev < DTR_LIM))
               tgt = TG_OSC_DTR;
         end
         FN_VOLT: begin
            if (!word.wr && at_main && dev_zero)
               tgt = TG_VOLT_MAIN;
            else if (!word.wr && at_dtr && (word.dev < VS_LIM))
               tgt = TG_VOLT_DTR;
         end
         FN_PWROFF: begin
            if (word.wr && at_main && dev_zero)
               tgt = TG_PWROFF;
         end
         FN_RESTART: begin
            if (word.wr && at_main && dev_zero)
               tgt = TG_RESTART;
         end
         FN_DISP: begin
            if (word.wr && at_main && dev_zero)
               tgt = TG_DISP;
         end
         default: tgt = TG_NONE;
      endcase
      if (!route_ok)
         tgt = TG_NONE;
   end

   assign ok = (tgt != TG_NONE);

endmodule

// File: rtl/cfg_osc_table.sv
module cfg_osc_table #(
   parameter int N     = 6,
   parameter int W     = 32,
   parameter int IDX_W = 12
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N*W-1:0]   init_vals,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] idx,
   input  logic [W-1:0]     wr_val,
   output logic [W-1:0]     rd_val
);

   if (N < 1 || N > 256) begin : g_bad_n
      $error("cfg_osc_table: N out of range");
   end
   if (W < 1) begin : g_bad_w
      $error("cfg_osc_table: W must be positive");
   end

   logic [W-1:0] ent [N];
   logic [N-1:0] hit;

   for (genvar i = 0; i < N; i++) begin : g_hit
      assign hit[i] = (idx == IDX_W'(i));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++)
            ent[i] <= init_vals[i*W +: W];
      end else if (wr_en) begin
         for (int i = 0; i < N; i++)
            if (hit[i])
               ent[i] <= wr_val;
      end
   end

   always_comb begin
      rd_val = '0;
      for (int i = 0; i < N; i++)
         if (hit[i])
            rd_val = ent[i];
   end

endmodule

// File: rtl/cfg_txn_engine.sv
module cfg_txn_engine
   import cfg_txn_pkg::*;
#(
   parameter int          MAIN_OSC_N  = 6,
   parameter int          DTR_OSC_N   = 2,
   parameter int          DTR_VSENS_N = 2,
   parameter logic [31:0] MAIN_VIO    = 32'd3300000
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          variant_en,
   input  logic                          bus_sel,
   input  logic                          bus_wr,
   input  logic [OFS_W-1:0]              bus_addr,
   input  logic [WORD_W-1:0]             bus_wdata,
   output logic [WORD_W-1:0]             bus_rdata,
   input  logic [DTR_OSC_N*WORD_W-1:0]   dtr_osc_init,
   input  logic [DTR_VSENS_N*WORD_W-1:0] dtr_volt,
   output logic                          pwr_off_req,
   output logic                          restart_req
);

   if (MAIN_OSC_N < 1 || MAIN_OSC_N > 64) begin : g_bad_main
      $error("cfg_txn_engine: MAIN_OSC_N out of range");
   end
   if (DTR_OSC_N < 1 || DTR_OSC_N > 64) begin : g_bad_dtr
      $error("cfg_txn_engine: DTR_OSC_N out of range");
   end
   if (DTR_VSENS_N < 1 || DTR_VSENS_N > 64) begin : g_bad_vs
      $error("cfg_txn_engine: DTR_VSENS_N out of range");
   end

   // bus decode
   logic wr_hit;
   logic hit_data;
   logic hit_ctrl;
   logic hit_stat;
   logic start_hit;

   assign wr_hit    = variant_en && bus_sel && bus_wr;
   assign hit_data  = wr_hit && (bus_addr == OFS_DATA);
   assign hit_ctrl  = wr_hit && (bus_addr == OFS_CTRL);
   assign hit_stat  = wr_hit && (bus_addr == OFS_STAT);
   assign start_hit = hit_ctrl && bus_wdata[WORD_W-1];

   // state
   cfg_word_t         cw_q;
   logic [WORD_W-1:0] data_q;
   logic [WORD_W-1:0] snap_q;
   logic [1:0]        stat_q;
   logic              go_q;
   logic              off_q;
   logic              rst_q;

   cfg_tgt_e          tgt;
   logic              dec_ok;

   cfg_txn_decode #(
      .MAIN_OSC_N  (MAIN_OSC_N),
      .DTR_OSC_N   (DTR_OSC_N),
      .DTR_VSENS_N (DTR_VSENS_N)
   ) u_dec (
      .word (cw_q),
      .tgt  (tgt),
      .ok   (dec_ok)
   );

   // main-board oscillator reset values
   logic [MAIN_OSC_N*WORD_W-1:0] main_init;
   for (genvar i = 0; i < MAIN_OSC_N; i++) begin : g_main_init
      if (i == 0) begin : g_mem
         assign main_init[i*WORD_W +: WORD_W] = 32'd50000000;
      end else if (i == 1) begin : g_disp
         assign main_init[i*WORD_W +: WORD_W] = 32'd23750000;
      end else begin : g_io
         assign main_init[i*WORD_W +: WORD_W] = 32'd24000000;
      end
   end

   logic [WORD_W-1:0] main_rd;
   logic [WORD_W-1:0] dtr_rd;
   logic              main_we;
   logic              dtr_we;

   assign main_we = go_q && cw_q.wr && (tgt == TG_OSC_MAIN);
   assign dtr_we  = go_q && cw_q.wr && (tgt == TG_OSC_DTR);

   cfg_osc_table #(
      .N     (MAIN_OSC_N),
      .W     (WORD_W),
      .IDX_W (DEV_W)
   ) u_main_osc (
      .clk       (clk),
      .rst_n     (rst_n),
      .init_vals (main_init),
      .wr_en     (main_we),
      .idx       (cw_q.dev),
      .wr_val    (snap_q),
      .rd_val    (main_rd)
   );

   cfg_osc_table #(
      .N     (DTR_OSC_N),
      .W     (WORD_W),
      .IDX_W (DEV_W)
   ) u_dtr_osc (
      .clk       (clk),
      .rst_n     (rst_n),
      .init_vals (dtr_osc_init),
      .wr_en     (dtr_we),
      .idx       (cw_q.dev),
      .wr_val    (snap_q),
      .rd_val    (dtr_rd)
   );

   // daughterboard sensor select
   logic [WORD_W-1:0] vs_rd;
   always_comb begin
      vs_rd = '0;
      for (int i = 0; i < DTR_VSENS_N; i++)
         if (cw_q.dev == DEV_W'(i))
            vs_rd = dtr_volt[i*WORD_W +: WORD_W];
   end

   logic [WORD_W-1:0] rd_result;
   always_comb begin
      case (tgt)
         TG_OSC_MAIN:  rd_result = main_rd;
         TG_OSC_DTR:   rd_result = dtr_rd;
         TG_VOLT_MAIN: rd_result = MAIN_VIO;
         TG_VOLT_DTR:  rd_result = vs_rd;
         default:      rd_result = '0;
      endcase
   end

   // register file and sequencing; the finishing transaction wins over bus writes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cw_q   <= '0;
         data_q <= '0;
         snap_q <= '0;
         stat_q <= '0;
         go_q   <= 1'b0;
         off_q  <= 1'b0;
         rst_q  <= 1'b0;
      end else begin
         go_q  <= start_hit;
         off_q <= go_q && cw_q.wr && (tgt == TG_PWROFF);
         rst_q <= go_q && cw_q.wr && (tgt == TG_RESTART);

         if (hit_ctrl)
            cw_q <= cfg_word_t'(bus_wdata & CTRL_KEEP);
         if (start_hit)
            snap_q <= data_q;

         if (go_q)
            stat_q <= {!dec_ok, 1'b1};
         else if (start_hit)
            stat_q <= 2'b00;
         else if (hit_stat)
            stat_q <= bus_wdata[1:0];

         if (go_q && !cw_q.wr && dec_ok)
            data_q <= rd_result;
         else if (hit_data)
            data_q <= bus_wdata;
      end
   end

   assign pwr_off_req = off_q;
   assign restart_req = rst_q;

   // read port
   always_comb begin
      bus_rdata = '0;
      if (variant_en && bus_sel) begin
         case (bus_addr)
            OFS_DATA: bus_rdata = data_q;
            OFS_CTRL: bus_rdata = WORD_W'(cw_q);
            OFS_STAT: bus_rdata = {{(WORD_W-2){1'b0}}, stat_q};
            default:  bus_rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/cfg_txn_chk.sv
module cfg_txn_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        variant_en,
   input logic        bus_sel,
   input logic        bus_wr,
   input logic [11:0] bus_addr,
   input logic [31:0] bus_wdata,
   input logic [31:0] bus_rdata,
   input logic        pwr_off_req,
   input logic        restart_req,
   input logic        go_q,
   input logic        dec_ok,
   input logic        cw_wr,
   input logic [1:0]  stat_q,
   input logic [31:0] data_q
);

   logic start_in;
   logic data_in;
   logic stat_in;

   assign start_in = variant_en && bus_sel && bus_wr && (bus_addr == 12'hA4) && bus_wdata[31];
   assign data_in  = variant_en && bus_sel && bus_wr && (bus_addr == 12'hA0);
   assign stat_in  = variant_en && bus_sel && bus_wr && (bus_addr == 12'hA8);

   p_ctrl_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (variant_en && bus_sel && !bus_wr && bus_addr == 12'hA4) |-> (bus_rdata[31] == 1'b0 && bus_rdata[19:18] == 2'b00));

   p_done_two_edges_r3: assert property (@(posedge clk) disable iff (!rst_n)
      start_in |=> ##1 stat_q[0]);

   p_fail_keeps_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (go_q && !dec_ok && !cw_wr && !data_in) |=> $stable(data_q));

   p_pulse_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(pwr_off_req && restart_req));

   p_pulse_with_success_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_off_req || restart_req) |-> (stat_q == 2'b01));

   p_stat_low_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_in && !go_q) |=> (stat_q == $past(bus_wdata[1:0])));

   p_gated_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !variant_en |-> (bus_rdata == 32'h0));

endmodule

bind cfg_txn_engine cfg_txn_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .variant_en  (variant_en),
   .bus_sel     (bus_sel),
   .bus_wr      (bus_wr),
   .bus_addr    (bus_addr),
   .bus_wdata   (bus_wdata),
   .bus_rdata   (bus_rdata),
   .pwr_off_req (pwr_off_req),
   .restart_req (restart_req),
   .go_q        (go_q),
   .dec_ok      (dec_ok),
   .cw_wr       (cw_q.wr),
   .stat_q      (stat_q),
   .data_q      (data_q)
);

// File: tb/tb_cfg_txn_engine.sv
module tb_cfg_txn_engine;

   localparam int CLK_P = 10;
   localparam int WD_CYCLES = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        variant_en = 1'b1;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [63:0] dtr_osc_init = {32'h0BEB_C200, 32'h02FA_F080};
   logic [63:0] dtr_volt     = {32'h000F_4240, 32'h0012_4F80};
   logic        pwr_off_req;
   logic        restart_req;

   always #(CLK_P/2) clk = ~clk;

   cfg_txn_engine dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .variant_en   (variant_en),
      .bus_sel      (bus_sel),
      .bus_wr       (bus_wr),
      .bus_addr     (bus_addr),
      .bus_wdata    (bus_wdata),
      .bus_rdata    (bus_rdata),
      .dtr_osc_init (dtr_osc_init),
      .dtr_volt     (dtr_volt),
      .pwr_off_req  (pwr_off_req),
      .restart_req  (restart_req)
   );

   typedef struct {
      logic [31:0] exp_data;
      logic [1:0]  exp_pulse;
      string       tag;
   } sb_item_t;

   sb_item_t sbq[$];
   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   localparam logic [11:0] A_DATA = 12'hA0;
   localparam logic [11:0] A_CTRL = 12'hA4;
   localparam logic [11:0] A_STAT = 12'hA8;
   localparam logic [31:0] OK_ST  = 32'h1;
   localparam logic [31:0] BAD_ST = 32'h3;

   // monitor: compares one queued item per read cycle, away from the edge
   always @(negedge clk) begin
      if (sbq.size() != 0) begin
         sb_item_t it;
         it = sbq.pop_front();
         n_chk++;
         if (bus_rdata !== it.exp_data || {pwr_off_req, restart_req} !== it.exp_pulse) begin
            n_err++;
            $display("FAIL %s: got data=%h pulse=%b expected data=%h pulse=%b",
                     it.tag, bus_rdata, {pwr_off_req, restart_req}, it.exp_data, it.exp_pulse);
         end
      end
   end

   task automatic drive(input logic sel, input logic wr, input logic [11:0] addr, input logic [31:0] d);
      @(posedge clk);
      #1;
      bus_sel   = sel;
      bus_wr    = wr;
      bus_addr  = addr;
      bus_wdata = d;
   endtask

   task automatic idle();
      drive(1'b0, 1'b0, 12'h0, 32'h0);
   endtask

   task automatic wr(input logic [11:0] addr, input logic [31:0] d);
      drive(1'b1, 1'b1, addr, d);
   endtask

   task automatic rd(input logic [11:0] addr, input logic [31:0] exp, input logic [1:0] pulse, input string tag);
      sb_item_t it;
      drive(1'b1, 1'b0, addr, 32'h0);
      it.exp_data  = exp;
      it.exp_pulse = pulse;
      it.tag       = tag;
      sbq.push_back(it);
   endtask

   // start a transaction, let the pending cycle pass, then read status
   task automatic txn(input logic [31:0] word, input logic [31:0] exp_st, input logic [1:0] pulse, input string tag);
      wr(A_CTRL, word);
      idle();
      rd(A_STAT, exp_st, pulse, tag);
   endtask

   task automatic set_variant(input logic v);
      @(posedge clk);
      #1;
      variant_en = v;
      bus_sel    = 1'b0;
      bus_wr     = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // reset state and offsets
      rd(A_DATA, 32'h0, 2'b00, "R1 data after reset");
      rd(A_CTRL, 32'h0, 2'b00, "R1 ctrl after reset");
      rd(A_STAT, 32'h0, 2'b00, "R1 status after reset");
      rd(12'h09C, 32'h0, 2'b00, "R12 offset below window");
      rd(12'h0AC, 32'h0, 2'b00, "R12 offset above window");

      // stored control bits without start
      wr(A_CTRL, 32'h7FFF_FFFF);
      rd(A_CTRL, 32'h7FF3_FFFF, 2'b00, "R2 undefined bits dropped");

      // main oscillator reads with timing of status
      wr(A_CTRL, 32'h8010_0000);
      rd(A_STAT, 32'h0, 2'b00, "R3 status cleared while pending");
      rd(A_STAT, OK_ST, 2'b00, "R3 complete after pending cycle");
      rd(A_DATA, 32'd50000000, 2'b00, "R1 main osc 0 reset value");
      rd(A_CTRL, 32'h0010_0000, 2'b00, "R2 start bit reads 0");
      txn(32'h8010_0001, OK_ST, 2'b00, "R6 main osc 1 read");
      rd(A_DATA, 32'd23750000, 2'b00, "R1 main osc 1 reset value");
      txn(32'h8010_0005, OK_ST, 2'b00, "R6 main osc 5 read");
      rd(A_DATA, 32'd24000000, 2'b00, "R1 main osc 5 reset value");
      txn(32'h8010_0006, BAD_ST, 2'b00, "R6 main osc index 6 rejected");
      rd(A_DATA, 32'd24000000, 2'b00, "R8 failed read keeps data");

      // oscillator write and read back
      wr(A_DATA, 32'h1234_5678);
      txn(32'hC010_0002, OK_ST, 2'b00, "R6 main osc 2 write");
      rd(A_DATA, 32'h1234_5678, 2'b00, "R8 write txn keeps data");
      wr(A_DATA, 32'h0);
      txn(32'h8010_0002, OK_ST, 2'b00, "R6 main osc 2 reread");
      rd(A_DATA, 32'h1234_5678, 2'b00, "R6 main osc 2 holds written value");

      // snapshot: data write during pending cycle is not used
      wr(A_DATA, 32'hAAAA_0000);
      wr(A_CTRL, 32'hC010_0003);
      wr(A_DATA, 32'h0000_5555);
      rd(A_STAT, OK_ST, 2'b00, "R6 snapshot write completes");
      rd(A_DATA, 32'h0000_5555, 2'b00, "R8 pending data write lands");
      txn(32'h8010_0003, OK_ST, 2'b00, "R6 snapshot reread");
      rd(A_DATA, 32'hAAAA_0000, 2'b00, "R6 value taken at start");

      // daughterboard oscillators
      txn(32'h8011_0000, OK_ST, 2'b00, "R6 dtr osc 0 read");
      rd(A_DATA, 32'h02FA_F080, 2'b00, "R6 dtr osc 0 reset value");
      wr(A_DATA, 32'h0000_0077);
      txn(32'hC011_0001, OK_ST, 2'b00, "R6 dtr osc 1 write");
      wr(A_DATA, 32'h0);
      txn(32'h8011_0001, OK_ST, 2'b00, "R6 dtr osc 1 reread");
      rd(A_DATA, 32'h0000_0077, 2'b00, "R6 dtr osc 1 value");
      txn(32'h8011_0002, BAD_ST, 2'b00, "R6 dtr osc index 2 rejected");

      // voltages
      txn(32'h8020_0000, OK_ST, 2'b00, "R7 main voltage read");
      rd(A_DATA, 32'd3300000, 2'b00, "R7 main voltage value");
      txn(32'h8020_0001, BAD_ST, 2'b00, "R7 main voltage device 1 rejected");
      txn(32'h8021_0001, OK_ST, 2'b00, "R7 dtr sensor 1 read");
      rd(A_DATA, 32'h000F_4240, 2'b00, "R7 dtr sensor 1 value");
      txn(32'h8021_0002, BAD_ST, 2'b00, "R7 dtr sensor 2 rejected");
      txn(32'hC020_0000, BAD_ST, 2'b00, "R5 voltage write rejected");

      // routing fields
      txn(32'h8410_0000, BAD_ST, 2'b00, "R4 controller 1 rejected");
      txn(32'h8010_1000, BAD_ST, 2'b00, "R4 position 1 rejected");
      txn(32'h8012_0000, BAD_ST, 2'b00, "R4 site 2 rejected");
      txn(32'h8013_0000, BAD_ST, 2'b00, "R4 site 3 rejected");
      rd(A_DATA, 32'h000F_4240, 2'b00, "R8 rejected reads keep data");

      // function codes
      txn(32'h8030_0000, BAD_ST, 2'b00, "R5 function 3 rejected");
      txn(32'h8080_0000, BAD_ST, 2'b00, "R5 power-off read rejected");
      txn(32'h80B0_0000, BAD_ST, 2'b00, "R5 display read rejected");

      // request pulses
      txn(32'hC080_0000, OK_ST, 2'b10, "R9 power-off pulse");
      rd(A_STAT, OK_ST, 2'b00, "R9 power-off pulse one cycle");
      txn(32'hC090_0000, OK_ST, 2'b01, "R9 restart pulse");
      rd(A_STAT, OK_ST, 2'b00, "R9 restart pulse one cycle");
      txn(32'hC0B0_0000, OK_ST, 2'b00, "R9 display write no pulse");
      txn(32'hC080_0001, BAD_ST, 2'b00, "R9 power-off device 1 no pulse");
      txn(32'hC091_0000, BAD_ST, 2'b00, "R9 restart site 1 no pulse");

      // status register writes
      wr(A_STAT, 32'hFFFF_FFFE);
      rd(A_STAT, 32'h2, 2'b00, "R10 status keeps low bits");
      wr(A_STAT, 32'h0000_0005);
      rd(A_STAT, 32'h1, 2'b00, "R10 status drops high bits");

      // variant disabled
      set_variant(1'b0);
      rd(A_DATA, 32'h0, 2'b00, "R11 data reads 0 when disabled");
      rd(A_CTRL, 32'h0, 2'b00, "R11 ctrl reads 0 when disabled");
      rd(A_STAT, 32'h0, 2'b00, "R11 status reads 0 when disabled");
      wr(A_DATA, 32'hDEAD_BEEF);
      wr(A_CTRL, 32'h8010_0000);
      wr(A_STAT, 32'h2);
      idle();
      idle();
      set_variant(1'b1);
      rd(A_DATA, 32'h000F_4240, 2'b00, "R11 data write ignored");
      rd(A_CTRL, 32'h4091_0000, 2'b00, "R11 ctrl write ignored");
      rd(A_STAT, 32'h1, 2'b00, "R11 status and start ignored");

      idle();
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule